// File: doc/BRIEF.md
# Bus Write Snooper with Windowed Capture and Serial Forwarding

The block sits beside an external processor whose clock it generates, and passively watches that processor's memory bus: address, data, write strobe and external chip-select. It samples every bus line on each rising and each falling edge of the target clock. A write is complete when the strobe, having been seen active together with the chip-select, is seen inactive at a later edge. If the address of that write lies inside a programmed window, the write becomes one captured entry. The entry holds the offset of the address inside the window and the data byte present at the edge where the strobe went inactive.

Captured entries go into a FIFO. A transmitter drains the FIFO onto a single asynchronous serial line and sends two bytes per entry: first the offset, then the data. A complete image of a memory region can then be rebuilt on a host from nothing but ordinary store instructions that the target performs into the window. Cycles to internal regions show on the address lines with the chip-select inactive and the data lines reading 0xFF, so they are never taken.

After a programmed number of captured writes, the block reports that it is finished and stops taking writes. A full FIFO at the moment a write arrives sets a sticky overflow flag. A one-cycle arm pulse starts a new dump.

Top module: `wrcap_snoop`

## Requirements
- R1: Bus lines are sampled at both rising and falling target clock edges. A write whose strobe is first seen at a falling edge and seen released at the next rising edge is captured just as one aligned to rising edges.
- R2: A write counts only when the active-low write strobe and the active-low chip-select are both low at the same sampling edge. A strobe with the chip-select high (internal cycle, data 0xFF) produces no entry.
- R3: The data byte of an entry is the one sampled at the edge where the strobe is first seen high again, not the one present while it was low.
- R4: Only addresses A with WIN_BASE <= A < WIN_BASE+WIN_SIZE are captured (defaults 0x4000 and 256). The stored offset is A-WIN_BASE; both ends of the window are included and the neighbours just outside are excluded.
- R5: Bus cycles whose strobe stays high (reads) produce no entry.
- R6: The serial line idles high. Each byte is sent as one low start bit, eight data bits least significant first and one high stop bit, each bit lasting CLK_HZ/BAUD clock cycles.
- R7: Entries are sent in capture order, each as the offset byte followed by the data byte.
- R8: After DUMP_LEN captured writes, `done_o` goes high and stays high. Later writes in the window produce no serial output until re-armed.
- R9: A write that is captured while the FIFO holds FIFO_DEPTH entries is dropped and sets `overflow_o`, which stays high. The entries already queued are still sent intact.
- R10: A one-cycle high on `arm_i` clears `done_o`, `overflow_o` and the capture count, and capturing resumes.
- R11: After reset, `tx_o` is high and `done_o` and `overflow_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the timebase of the generated target clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_i | input | 1 | One-cycle pulse starting a new dump |
| tgt_clk_i | input | 1 | Current level of the target clock |
| bus_addr_i | input | ADDR_W | Target address lines |
| bus_data_i | input | 8 | Target data lines |
| bus_wr_n_i | input | 1 | Target write strobe, active low |
| bus_cs_n_i | input | 1 | External-region chip-select, active low |
| tx_o | output | 1 | Serial line to host |
| done_o | output | 1 | Dump length reached |
| overflow_o | output | 1 | Sticky: a capture was lost to a full FIFO |

## Verification
The hardest state to reach is a full FIFO with the transmitter busy, because draining one entry takes twenty bit times while a bus write takes a few clock cycles. The bench runs the serial line at sixteen clocks per bit with a sixteen-entry FIFO and fires an unbroken burst of twenty window writes. One entry is already in flight, sixteen wait in the FIFO, and the last three must be dropped. The done condition is reached by spacing writes far enough apart that the FIFO never fills, so the two flags are tested separately.

// File: rtl/wrcap_pkg.sv
package wrcap_pkg;

   localparam int unsigned BYTE_W = 8;

   typedef struct packed {
      logic [BYTE_W-1:0] ofs;
      logic [BYTE_W-1:0] data;
   } cap_entry_t;

   localparam int unsigned ENTRY_W = $bits(cap_entry_t);

   typedef enum logic [1:0] {
      DR_IDLE = 2'd0,
      DR_OFS  = 2'd1,
      DR_DAT  = 2'd2
   } drain_st_t;

endpackage

// File: rtl/wrcap_bus_sampler.sv
module wrcap_bus_sampler
   import wrcap_pkg::*;
#(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned WIN_BASE   = 16'h4000,
   parameter int unsigned WIN_SIZE   = 256,
   parameter bit          BOTH_EDGES = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tgt_clk_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [BYTE_W-1:0] data_i,
   input  logic              wr_n_i,
   input  logic              cs_n_i,
   output logic              cap_vld_o,
   output cap_entry_t        cap_o
);

   localparam int unsigned XW = ADDR_W + 1;

   if (WIN_SIZE == 0 || WIN_SIZE > (1 << BYTE_W)) begin : g_bad_size
      $error("WIN_SIZE must be 1..256");
   end
   if (WIN_BASE + WIN_SIZE > (1 << ADDR_W)) begin : g_bad_base
      $error("capture window exceeds address space");
   end

   logic              tclk_q;
   logic              tedge;
   logic              s_vld;
   logic [ADDR_W-1:0] s_addr;
   logic [BYTE_W-1:0] s_data;
   logic              s_wr;
   logic              s_cs;
   logic [XW-1:0]     ofs_full;
   logic              in_win;
   logic              pend;
   logic [BYTE_W-1:0] pend_ofs;

   if (BOTH_EDGES) begin : g_both
      assign tedge = tgt_clk_i ^ tclk_q;
   end else begin : g_rise
      assign tedge = tgt_clk_i & ~tclk_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tclk_q <= 1'b0;
         s_vld  <= 1'b0;
         s_addr <= '0;
         s_data <= '0;
         s_wr   <= 1'b0;
         s_cs   <= 1'b0;
      end else begin
         tclk_q <= tgt_clk_i;
         s_vld  <= tedge;
         if (tedge) begin
            s_addr <= addr_i;
            s_data <= data_i;
            s_wr   <= ~wr_n_i;
            s_cs   <= ~cs_n_i;
         end
      end
   end

   always_comb begin
      ofs_full = {1'b0, s_addr} - XW'(WIN_BASE);
      in_win   = ({1'b0, s_addr} >= XW'(WIN_BASE)) && (ofs_full < XW'(WIN_SIZE));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend      <= 1'b0;
         pend_ofs  <= '0;
         cap_vld_o <= 1'b0;
         cap_o     <= '0;
      end else begin
         cap_vld_o <= 1'b0;
         if (s_vld) begin
            if (s_wr) begin
               pend     <= s_cs && in_win;
               pend_ofs <= ofs_full[BYTE_W-1:0];
            end else begin
               pend       <= 1'b0;
               cap_vld_o  <= pend;
               cap_o.ofs  <= pend_ofs;
               cap_o.data <= s_data;
            end
         end
      end
   end

   // R3: a capture only follows a sampling edge
   a_r3_cap_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
      cap_vld_o |-> $past(s_vld));

endmodule

// File: rtl/wrcap_fifo.sv
module wrcap_fifo #(
   parameter int unsigned DEPTH = 512,
   parameter int unsigned W     = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push_i,
   input  logic [W-1:0] wdata_i,
   input  logic         pop_i,
   output logic [W-1:0] rdata_o,
   output logic         full_o,
   output logic         empty_o
);

   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("FIFO depth must be a power of two of at least 2");
   end

   logic [W-1:0] mem [DEPTH];
   logic [AW:0]  wr_ptr;
   logic [AW:0]  rd_ptr;
   logic         do_push;
   logic         do_pop;

   assign empty_o = (wr_ptr == rd_ptr);
   assign full_o  = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
   assign do_push = push_i && !full_o;
   assign do_pop  = pop_i && !empty_o;
   assign rdata_o = mem[rd_ptr[AW-1:0]];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr[AW-1:0]] <= wdata_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      end
   end

   // R7: the drain never reads an empty queue
   a_r7_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i |-> !empty_o);

endmodule

// File: rtl/wrcap_uart_tx.sv
module wrcap_uart_tx
   import wrcap_pkg::*;
#(
   parameter int unsigned BIT_CLKS = 434
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [BYTE_W-1:0] byte_i,
   output logic              busy_o,
   output logic              tx_o
);

   localparam int unsigned FRAME_W = BYTE_W + 2;
   localparam int unsigned CW      = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;
   localparam int unsigned NW      = $clog2(FRAME_W + 1);

   if (BIT_CLKS < 2) begin : g_bad_div
      $error("at least two clocks per serial bit are required");
   end

   logic [FRAME_W-1:0] sh;
   logic [CW-1:0]      cnt;
   logic [NW-1:0]      nbits;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh     <= '1;
         cnt    <= '0;
         nbits  <= '0;
         busy_o <= 1'b0;
      end else if (start_i && !busy_o) begin
         sh     <= {1'b1, byte_i, 1'b0};
         cnt    <= CW'(BIT_CLKS - 1);
         nbits  <= NW'(FRAME_W);
         busy_o <= 1'b1;
      end else if (busy_o) begin
         if (cnt == '0) begin
            cnt   <= CW'(BIT_CLKS - 1);
            sh    <= {1'b1, sh[FRAME_W-1:1]};
            nbits <= nbits - 1'b1;
            if (nbits == NW'(1)) busy_o <= 1'b0;
         end else begin
            cnt <= cnt - 1'b1;
         end
      end
   end

   assign tx_o = busy_o ? sh[0] : 1'b1;

   // R6: a frame begins with a low start bit
   a_r6_start_bit_low: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> !tx_o);

   // R6: the driver never starts a byte over a running frame
   a_r6_start_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> !busy_o);

endmodule

// File: rtl/wrcap_snoop.sv
module wrcap_snoop
   import wrcap_pkg::*;
#(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned CLK_HZ     = 50_000_000,
   parameter int unsigned BAUD       = 115_200,
   parameter int unsigned WIN_BASE   = 16'h4000,
   parameter int unsigned WIN_SIZE   = 256,
   parameter int unsigned DUMP_LEN   = 256,
   parameter int unsigned FIFO_DEPTH = 512
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm_i,
   input  logic              tgt_clk_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [7:0]        bus_data_i,
   input  logic              bus_wr_n_i,
   input  logic              bus_cs_n_i,
   output logic              tx_o,
   output logic              done_o,
   output logic              overflow_o
);

   localparam int unsigned BIT_CLKS = CLK_HZ / BAUD;
   localparam int unsigned CNT_W    = $clog2(DUMP_LEN + 1);

   if (DUMP_LEN == 0) begin : g_bad_len
      $error("DUMP_LEN must be nonzero");
   end

   logic              cap_vld;
   cap_entry_t        cap;
   logic              take;
   logic              fifo_full;
   logic              fifo_empty;
   logic              pop;
   cap_entry_t        head;
   cap_entry_t        cur;
   logic              tx_start;
   logic [BYTE_W-1:0] tx_byte;
   logic              tx_busy;
   logic [CNT_W-1:0]  cnt;
   drain_st_t         st;

   wrcap_bus_sampler #(
      .ADDR_W     (ADDR_W),
      .WIN_BASE   (WIN_BASE),
      .WIN_SIZE   (WIN_SIZE),
      .BOTH_EDGES (1'b1)
   ) u_smp (
      .clk       (clk),
      .rst_n     (rst_n),
      .tgt_clk_i (tgt_clk_i),
      .addr_i    (bus_addr_i),
      .data_i    (bus_data_i),
      .wr_n_i    (bus_wr_n_i),
      .cs_n_i    (bus_cs_n_i),
      .cap_vld_o (cap_vld),
      .cap_o     (cap)
   );

   assign take = cap_vld && !done_o && !arm_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt        <= '0;
         done_o     <= 1'b0;
         overflow_o <= 1'b0;
      end else if (arm_i) begin
         cnt        <= '0;
         done_o     <= 1'b0;
         overflow_o <= 1'b0;
      end else if (take) begin
         cnt <= cnt + 1'b1;
         if (cnt == CNT_W'(DUMP_LEN - 1)) done_o <= 1'b1;
         if (fifo_full) overflow_o <= 1'b1;
      end
   end

   wrcap_fifo #(
      .DEPTH (FIFO_DEPTH),
      .W     (ENTRY_W)
   ) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_i  (take),
      .wdata_i (cap),
      .pop_i   (pop),
      .rdata_o (head),
      .full_o  (fifo_full),
      .empty_o (fifo_empty)
   );

   always_comb begin
      pop      = 1'b0;
      tx_start = 1'b0;
      tx_byte  = cur.data;
      unique case (st)
         DR_IDLE: begin
            tx_byte = head.ofs;
            if (!fifo_empty && !tx_busy) begin
               pop      = 1'b1;
               tx_start = 1'b1;
            end
         end
         DR_OFS:  tx_start = !tx_busy;
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st  <= DR_IDLE;
         cur <= '0;
      end else begin
         unique case (st)
            DR_IDLE: if (pop) begin
               cur <= head;
               st  <= DR_OFS;
            end
            DR_OFS:  if (!tx_busy) st <= DR_DAT;
            DR_DAT:  if (!tx_busy) st <= DR_IDLE;
            default: st <= DR_IDLE;
         endcase
      end
   end

   wrcap_uart_tx #(
      .BIT_CLKS (BIT_CLKS)
   ) u_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (tx_start),
      .byte_i  (tx_byte),
      .busy_o  (tx_busy),
      .tx_o    (tx_o)
   );

   // R8: done holds until re-armed
   a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !arm_i) |=> done_o);

   // R9: overflow holds until re-armed
   a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow_o && !arm_i) |=> overflow_o);

   // R10: an arm pulse clears both flags
   a_r10_arm_clears: assert property (@(posedge clk) disable iff (!rst_n)
      arm_i |=> (!done_o && !overflow_o));

endmodule

// File: tb/wrcap_snoop_tb_top.sv
module wrcap_snoop_tb_top;

   localparam int CLK_HZ   = 50_000_000;
   localparam int BAUD     = 3_125_000;
   localparam int BIT_CLKS = CLK_HZ / BAUD;
   localparam int DLEN     = 32;
   localparam int FDEPTH   = 16;
   localparam int HALF     = 3;
   localparam int NVEC     = 8;

   typedef struct packed {
      logic [15:0] a;
      logic [7:0]  d;
      logic        cs;
      logic        we;
      logic        hit;
   } vec_t;

   // offset/data pairs; hit marks the writes that must be forwarded
   localparam vec_t VECS [NVEC] = '{
      '{16'h4000, 8'h11, 1'b1, 1'b1, 1'b1},   // R4 lower edge
      '{16'h40FF, 8'h22, 1'b1, 1'b1, 1'b1},   // R4 upper edge
      '{16'h3FFF, 8'h33, 1'b1, 1'b1, 1'b0},   // R4 below window
      '{16'h4100, 8'h44, 1'b1, 1'b1, 1'b0},   // R4 above window
      '{16'h4055, 8'hFF, 1'b0, 1'b1, 1'b0},   // R2 internal cycle
      '{16'h4010, 8'h66, 1'b1, 1'b0, 1'b0},   // R5 read
      '{16'h4012, 8'h77, 1'b1, 1'b1, 1'b1},   // R3 late data
      '{16'h40A0, 8'h88, 1'b1, 1'b1, 1'b1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        arm = 1'b0;
   logic        tgt_clk = 1'b0;
   logic [15:0] addr = '0;
   logic [7:0]  data = '0;
   logic        wr_n = 1'b1;
   logic        cs_n = 1'b1;
   logic        tx;
   logic        done;
   logic        ovf;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;
   logic [7:0] rxq[$];
   logic [7:0] expq[$];

   always #10 clk = ~clk;

   wrcap_snoop #(
      .ADDR_W     (16),
      .CLK_HZ     (CLK_HZ),
      .BAUD       (BAUD),
      .WIN_BASE   (16'h4000),
      .WIN_SIZE   (256),
      .DUMP_LEN   (DLEN),
      .FIFO_DEPTH (FDEPTH)
   ) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .arm_i      (arm),
      .tgt_clk_i  (tgt_clk),
      .bus_addr_i (addr),
      .bus_data_i (data),
      .bus_wr_n_i (wr_n),
      .bus_cs_n_i (cs_n),
      .tx_o       (tx),
      .done_o     (done),
      .overflow_o (ovf)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // serial receiver, R6 framing
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && tx === 1'b0) begin
            logic [7:0] b;
            repeat (BIT_CLKS / 2) @(negedge clk);
            chk(tx === 1'b0, "R6 start bit", tx, 0);
            for (int k = 0; k < 8; k++) begin
               repeat (BIT_CLKS) @(negedge clk);
               b[k] = tx;
            end
            repeat (BIT_CLKS) @(negedge clk);
            chk(tx === 1'b1, "R6 stop bit", tx, 1);
            rxq.push_back(b);
         end
      end
   end

   task automatic edge_step();
      @(negedge clk);
      tgt_clk = ~tgt_clk;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic bus_cycle(input logic [15:0] a, input logic [7:0] d,
                            input logic c, input logic w);
      @(negedge clk);
      addr = a;
      data = ~d;
      wr_n = ~w;
      cs_n = ~c;
      edge_step();
      data = d;
      wr_n = 1'b1;
      edge_step();
      cs_n = 1'b1;
   endtask

   task automatic expect_entry(input logic [7:0] o, input logic [7:0] d);
      expq.push_back(o);
      expq.push_back(d);
   endtask

   task automatic compare(input string req);
      chk(rxq.size() == expq.size(), {req, " byte count"}, rxq.size(), expq.size());
      for (int k = 0; k < rxq.size() && k < expq.size(); k++)
         chk(rxq[k] === expq[k], {req, " byte"}, rxq[k], expq[k]);
      rxq.delete();
      expq.delete();
   endtask

   task automatic pulse_arm();
      @(negedge clk);
      arm = 1'b1;
      @(negedge clk);
      arm = 1'b0;
   endtask

   initial begin
      repeat (150_000) @(negedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hang expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(tx === 1'b1, "R11 tx idle", tx, 1);
      chk(done === 1'b0, "R11 done", done, 0);
      chk(ovf === 1'b0, "R11 overflow", ovf, 0);

      // table: R2 R3 R4 R5 R7
      for (int i = 0; i < NVEC; i++) begin
         bus_cycle(VECS[i].a, VECS[i].d, VECS[i].cs, VECS[i].we);
         if (VECS[i].hit) expect_entry(VECS[i].a[7:0], VECS[i].d);
         repeat (4) @(negedge clk);
      end
      repeat (2500) @(negedge clk);
      compare("R2 R3 R4 R5 R7 table");

      // R1: shift by one edge so the write starts on a falling edge
      edge_step();
      bus_cycle(16'h4021, 8'h5C, 1'b1, 1'b1);
      expect_entry(8'h21, 8'h5C);
      repeat (800) @(negedge clk);
      compare("R1 falling-edge write");
      edge_step();

      // R8: dump length reached
      pulse_arm();
      for (int i = 0; i < DLEN; i++) begin
         bus_cycle(16'h4000 + 16'(i), 8'(i) ^ 8'h5A, 1'b1, 1'b1);
         expect_entry(8'(i), 8'(i) ^ 8'h5A);
         repeat (400) @(negedge clk);
         if (i == DLEN - 2) chk(done === 1'b0, "R8 done early", done, 0);
      end
      chk(done === 1'b1, "R8 done set", done, 1);
      bus_cycle(16'h4001, 8'hE7, 1'b1, 1'b1);
      repeat (800) @(negedge clk);
      chk(done === 1'b1, "R8 done held", done, 1);
      compare("R8 writes after done ignored");

      // R10 then R9: burst into a full FIFO
      pulse_arm();
      chk(done === 1'b0, "R10 done cleared", done, 0);
      for (int i = 0; i < 20; i++) begin
         bus_cycle(16'h4080 + 16'(i), 8'hC0 + 8'(i), 1'b1, 1'b1);
         if (i < FDEPTH + 1) expect_entry(8'h80 + 8'(i), 8'hC0 + 8'(i));
      end
      repeat (8000) @(negedge clk);
      chk(ovf === 1'b1, "R9 overflow set", ovf, 1);
      compare("R9 queued entries intact");

      pulse_arm();
      chk(ovf === 1'b0, "R10 overflow cleared", ovf, 0);
      bus_cycle(16'h4033, 8'h5E, 1'b1, 1'b1);
      expect_entry(8'h33, 8'h5E);
      repeat (800) @(negedge clk);
      compare("R10 capture resumes");
      chk(ovf === 1'b0 && done === 1'b0, "R10 flags stay low", {ovf, done}, 0);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule